// File: doc/BRIEF.md
# Double-Buffered Profile Update Controller

This block keeps two copies of the tuning state for a bank of synthesis channels. Each channel has a table of profiles, and each profile holds a frequency word, a phase word and an amplitude word. Writes from the configuration side go only into a staging copy. The working copy drives the outputs, and it changes only when a transfer is triggered. A transfer copies the whole staging copy of every channel into the working copy in a single cycle.

Two sources can trigger a transfer: a rising edge on a commit strobe, or any change on the profile-select inputs. Both inputs are sampled once per period of a divided sync clock, which the block generates and drives out. External logic launches its strobe and profile changes from that clock, so every update reaches the outputs after a fixed number of cycles. The profile that was sampled together with the transfer selects which table entry each channel presents.

Top module: `prof_upd_ctrl`

## Requirements
- R1: `sync_clk_o` is the system clock divided by `SYNC_DIV` (4 by default). It is high for the first half of each period and low for the second half. Reset leaves it high, and it is driven from a register.
- R2: `update_i` and `profile_i` are sampled only at the clock edge where `sync_clk_o` rises. A pulse or glitch that falls entirely between two such edges has no effect.
- R3: When the sampled `update_i` is 1 and the previous sample was 0, `xfer_o` goes high for exactly one cycle, starting at that sampling edge. On the next clock edge the staging copy of every channel and profile is copied into the working copy.
- R4: When the sampled `profile_i` differs from the previous sample, the same one-cycle transfer takes place as in R3.
- R5: When a strobe rising edge and a profile change appear in the same sample, only one transfer pulse is generated.
- R6: Holding `update_i` high, a falling `update_i`, or a steady `profile_i` triggers no further transfer.
- R7: For channel c, outputs `act_freq_o[c*FREQ_W +: FREQ_W]`, `act_phase_o[c*PHASE_W +: PHASE_W]` and `act_amp_o[c*AMP_W +: AMP_W]` show the working entry at the profile index that was sampled with the latest transfer. The index is the unsigned value of `profile_i`. The outputs change only on the edge that follows a `xfer_o` cycle.
- R8: A staging write (`wr_en_i`=1 writes the three words into the entry addressed by `wr_ch_i` and `wr_prof_i`) does not change the outputs until a later transfer. A write on the same edge as the copy, meaning during the cycle `xfer_o` is high, appears only at the next transfer.
- R9: While `rst_ni` is 0, every staging and working word is 0, the selected profile is 0, `xfer_o` is 0 and `sync_clk_o` is 1. The previous-sample registers reset to `update_i`=0 and `profile_i`=0.
- R10: A transfer updates all channels together. Each channel presents its own entry, so a write to one channel never shows up on another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Staging write enable |
| wr_ch_i | input | CH_W | Channel addressed by the write |
| wr_prof_i | input | PS_W | Profile entry addressed by the write |
| wr_freq_i | input | FREQ_W | Frequency word to stage |
| wr_phase_i | input | PHASE_W | Phase word to stage |
| wr_amp_i | input | AMP_W | Amplitude word to stage |
| update_i | input | 1 | Commit strobe, acts on its sampled rising edge |
| profile_i | input | PS_W | Profile select, any sampled change commits |
| sync_clk_o | output | 1 | Divided sync clock for launching the control inputs |
| xfer_o | output | 1 | One-cycle transfer pulse |
| act_freq_o | output | NUM_CH*FREQ_W | Working frequency words, channel 0 in the low lane |
| act_phase_o | output | NUM_CH*PHASE_W | Working phase words |
| act_amp_o | output | NUM_CH*AMP_W | Working amplitude words |

## Verification
The bench builds the block with its default parameters: four channels, sixteen profiles, 32/14/10-bit words and a divide-by-four sync clock. Every staging entry of every channel gets a distinct value, so a transfer that copies the wrong channel, the wrong profile or a stale entry changes the compared output vectors. With a divide-by-four clock, there is room to place one-cycle glitches strictly between sampling edges. It also lets a staging write land exactly on the copy edge, and lets a strobe edge and a profile change be presented together.

// File: rtl/prof_upd_pkg.sv
package prof_upd_pkg;

  // source of a commit request seen in one sample
  typedef enum logic [1:0] {
    TRIG_NONE    = 2'b00,
    TRIG_STROBE  = 2'b01,
    TRIG_PROFILE = 2'b10,
    TRIG_BOTH    = 2'b11
  } trig_e;

  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/prof_upd_syncdiv.sv
module prof_upd_syncdiv #(
  parameter int unsigned SYNC_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic sync_o,
  output logic smp_o
);
  localparam int unsigned CNT_W = prof_upd_pkg::idx_w(SYNC_DIV);
  localparam int unsigned HALF  = SYNC_DIV / 2;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SYNC_DIV - 1);
  localparam logic [CNT_W-1:0] HALF_C = CNT_W'(HALF);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sync_q;

  assign cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  // sample strobe: the edge at which sync_o rises
  assign smp_o  = (cnt_q == LAST);
  assign sync_o = sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sync_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      sync_q <= (cnt_d < HALF_C);
    end
  end

endmodule

// File: rtl/prof_upd_sampler.sv
module prof_upd_sampler #(
  parameter int unsigned PS_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            smp_i,
  input  logic            upd_i,
  input  logic [PS_W-1:0] prof_i,
  output logic            xfer_o,
  output logic [PS_W-1:0] prof_o
);
  import prof_upd_pkg::*;

  logic            upd_q;
  logic [PS_W-1:0] prof_q;
  logic            xfer_q;
  trig_e           trig;

  assign trig   = trig_e'({prof_i != prof_q, upd_i & ~upd_q});
  assign xfer_o = xfer_q;
  assign prof_o = prof_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upd_q  <= 1'b0;
      prof_q <= '0;
      xfer_q <= 1'b0;
    end else begin
      // one pulse per sample whatever the trigger mix
      xfer_q <= smp_i && (trig != TRIG_NONE);
      if (smp_i) begin
        upd_q  <= upd_i;
        prof_q <= prof_i;
      end
    end
  end

endmodule

// File: rtl/prof_upd_bank.sv
module prof_upd_bank #(
  parameter int unsigned NUM_PROF = 16,
  parameter int unsigned FREQ_W   = 32,
  parameter int unsigned PHASE_W  = 14,
  parameter int unsigned AMP_W    = 10,
  parameter int unsigned PS_W     = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [PS_W-1:0]    wr_prof_i,
  input  logic [FREQ_W-1:0]  wr_freq_i,
  input  logic [PHASE_W-1:0] wr_phase_i,
  input  logic [AMP_W-1:0]   wr_amp_i,
  input  logic               xfer_i,
  input  logic [PS_W-1:0]    sel_i,
  output logic [FREQ_W-1:0]  freq_o,
  output logic [PHASE_W-1:0] phase_o,
  output logic [AMP_W-1:0]   amp_o
);
  logic [FREQ_W-1:0]  stg_f [NUM_PROF];
  logic [PHASE_W-1:0] stg_p [NUM_PROF];
  logic [AMP_W-1:0]   stg_a [NUM_PROF];
  logic [FREQ_W-1:0]  wrk_f [NUM_PROF];
  logic [PHASE_W-1:0] wrk_p [NUM_PROF];
  logic [AMP_W-1:0]   wrk_a [NUM_PROF];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_PROF; i++) begin
        stg_f[i] <= '0;
        stg_p[i] <= '0;
        stg_a[i] <= '0;
      end
    end else if (wr_en_i) begin
      stg_f[wr_prof_i] <= wr_freq_i;
      stg_p[wr_prof_i] <= wr_phase_i;
      stg_a[wr_prof_i] <= wr_amp_i;
    end
  end

  // copy takes the pre-edge staging value, so a same-edge write waits
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_PROF; i++) begin
        wrk_f[i] <= '0;
        wrk_p[i] <= '0;
        wrk_a[i] <= '0;
      end
    end else if (xfer_i) begin
      for (int i = 0; i < NUM_PROF; i++) begin
        wrk_f[i] <= stg_f[i];
        wrk_p[i] <= stg_p[i];
        wrk_a[i] <= stg_a[i];
      end
    end
  end

  assign freq_o  = wrk_f[sel_i];
  assign phase_o = wrk_p[sel_i];
  assign amp_o   = wrk_a[sel_i];

endmodule

// File: rtl/prof_upd_ctrl.sv
module prof_upd_ctrl #(
  parameter int unsigned NUM_CH   = 4,
  parameter int unsigned NUM_PROF = 16,
  parameter int unsigned FREQ_W   = 32,
  parameter int unsigned PHASE_W  = 14,
  parameter int unsigned AMP_W    = 10,
  parameter int unsigned SYNC_DIV = 4,
  localparam int unsigned CH_W    = prof_upd_pkg::idx_w(NUM_CH),
  localparam int unsigned PS_W    = prof_upd_pkg::idx_w(NUM_PROF)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [CH_W-1:0]           wr_ch_i,
  input  logic [PS_W-1:0]           wr_prof_i,
  input  logic [FREQ_W-1:0]         wr_freq_i,
  input  logic [PHASE_W-1:0]        wr_phase_i,
  input  logic [AMP_W-1:0]          wr_amp_i,
  input  logic                      update_i,
  input  logic [PS_W-1:0]           profile_i,
  output logic                      sync_clk_o,
  output logic                      xfer_o,
  output logic [NUM_CH*FREQ_W-1:0]  act_freq_o,
  output logic [NUM_CH*PHASE_W-1:0] act_phase_o,
  output logic [NUM_CH*AMP_W-1:0]   act_amp_o
);
  logic            smp;
  logic            xfer;
  logic [PS_W-1:0] prof_smp;
  logic [PS_W-1:0] prof_act_q;

  prof_upd_syncdiv #(.SYNC_DIV(SYNC_DIV)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sync_o (sync_clk_o),
    .smp_o  (smp)
  );

  prof_upd_sampler #(.PS_W(PS_W)) u_smp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .smp_i  (smp),
    .upd_i  (update_i),
    .prof_i (profile_i),
    .xfer_o (xfer),
    .prof_o (prof_smp)
  );

  assign xfer_o = xfer;

  // selection moves on the copy edge, together with the data
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   prof_act_q <= '0;
    else if (xfer) prof_act_q <= prof_smp;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    prof_upd_bank #(
      .NUM_PROF (NUM_PROF),
      .FREQ_W   (FREQ_W),
      .PHASE_W  (PHASE_W),
      .AMP_W    (AMP_W),
      .PS_W     (PS_W)
    ) u_bank (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_en_i    (wr_en_i && (wr_ch_i == CH_W'(c))),
      .wr_prof_i  (wr_prof_i),
      .wr_freq_i  (wr_freq_i),
      .wr_phase_i (wr_phase_i),
      .wr_amp_i   (wr_amp_i),
      .xfer_i     (xfer),
      .sel_i      (prof_act_q),
      .freq_o     (act_freq_o[c*FREQ_W +: FREQ_W]),
      .phase_o    (act_phase_o[c*PHASE_W +: PHASE_W]),
      .amp_o      (act_amp_o[c*AMP_W +: AMP_W])
    );
  end

endmodule

// File: rtl/prof_upd_chk.sv
module prof_upd_chk #(
  parameter int unsigned FV_W = 128,
  parameter int unsigned PV_W = 56,
  parameter int unsigned AV_W = 40
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            sync_clk_o,
  input logic            xfer_o,
  input logic [FV_W-1:0] act_freq_o,
  input logic [PV_W-1:0] act_phase_o,
  input logic [AV_W-1:0] act_amp_o
);

  p_sync_high_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_clk_o) |=> sync_clk_o ##1 !sync_clk_o);

  p_sync_low_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sync_clk_o) |=> !sync_clk_o ##1 sync_clk_o);

  p_xfer_on_sync_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_o |-> $rose(sync_clk_o));

  p_xfer_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_o |=> !xfer_o);

  p_act_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xfer_o |=> ($stable(act_freq_o) && $stable(act_phase_o) && $stable(act_amp_o)));

endmodule

bind prof_upd_ctrl prof_upd_chk #(
  .FV_W (NUM_CH*FREQ_W),
  .PV_W (NUM_CH*PHASE_W),
  .AV_W (NUM_CH*AMP_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sync_clk_o  (sync_clk_o),
  .xfer_o      (xfer_o),
  .act_freq_o  (act_freq_o),
  .act_phase_o (act_phase_o),
  .act_amp_o   (act_amp_o)
);

// File: tb/sim_prof_upd_ctrl.sv
`timescale 1ns/1ps
module sim_prof_upd_ctrl;
  localparam int NCH = 4, NPR = 16, FW = 32, PW = 14, AW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_ch = '0;
  logic [3:0] wr_prof = '0;
  logic [FW-1:0] wr_f = '0;
  logic [PW-1:0] wr_p = '0;
  logic [AW-1:0] wr_a = '0;
  logic update = 1'b0;
  logic [3:0] profile = '0;
  logic sync_clk, xfer;
  logic [NCH*FW-1:0] act_f;
  logic [NCH*PW-1:0] act_p;
  logic [NCH*AW-1:0] act_a;

  always #4 clk = ~clk;

  prof_upd_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_ch_i(wr_ch),
    .wr_prof_i(wr_prof), .wr_freq_i(wr_f), .wr_phase_i(wr_p), .wr_amp_i(wr_a),
    .update_i(update), .profile_i(profile), .sync_clk_o(sync_clk), .xfer_o(xfer),
    .act_freq_o(act_f), .act_phase_o(act_p), .act_amp_o(act_a)
  );

  int n_chk = 0, n_fail = 0, xfer_cnt = 0;
  logic [FW-1:0] m_f [NCH][NPR];
  logic [PW-1:0] m_p [NCH][NPR];
  logic [AW-1:0] m_a [NCH][NPR];
  logic [NCH*FW-1:0] q_f [$];
  logic [NCH*PW-1:0] q_p [$];
  logic [NCH*AW-1:0] q_a [$];
  string             q_t [$];

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic push_exp(int prof, string tag);
    logic [NCH*FW-1:0] f;
    logic [NCH*PW-1:0] p;
    logic [NCH*AW-1:0] a;
    for (int c = 0; c < NCH; c++) begin
      f[c*FW +: FW] = m_f[c][prof];
      p[c*PW +: PW] = m_p[c][prof];
      a[c*AW +: AW] = m_a[c][prof];
    end
    q_f.push_back(f); q_p.push_back(p); q_a.push_back(a); q_t.push_back(tag);
  endtask

  task automatic stage(int c, int p, int gen);
    @(negedge clk);
    wr_en = 1'b1; wr_ch = 2'(c); wr_prof = 4'(p);
    wr_f = {8'(c), 8'(p), 16'(gen * 16'h111 + 16'h5a)};
    wr_p = 14'(c * 1000 + p * 37 + gen);
    wr_a = 10'(c * 100 + p * 7 + gen + 1);
    m_f[c][p] = wr_f; m_p[c][p] = wr_p; m_a[c][p] = wr_a;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic drive(logic upd, int prof);
    @(posedge sync_clk);
    @(negedge clk);
    update = upd; profile = 4'(prof);
  endtask

  task automatic settle();
    @(posedge sync_clk);
    repeat (3) @(negedge clk);
  endtask

  // monitor: pop one expected item per transfer, compare after the copy edge
  logic pend = 1'b0;
  always @(negedge clk) begin
    if (!rst_n) pend = 1'b0;
    else begin
      if (pend) begin
        string t;
        t = q_t.pop_front();
        chk({t, " freq"},  128'(act_f), 128'(q_f.pop_front()));
        chk({t, " phase"}, 128'(act_p), 128'(q_p.pop_front()));
        chk({t, " amp"},   128'(act_a), 128'(q_a.pop_front()));
        pend = 1'b0;
      end
      if (xfer) begin
        xfer_cnt++;
        if (q_t.size() == 0) begin
          n_chk++; n_fail++;
          $display("FAIL R6 unexpected transfer act=1 exp=0");
        end else pend = 1'b1;
      end
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    realtime t0, t1, t2;
    int base;
    for (int c = 0; c < NCH; c++)
      for (int p = 0; p < NPR; p++) begin
        m_f[c][p] = '0; m_p[c][p] = '0; m_a[c][p] = '0;
      end
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 sync", 128'(sync_clk), 128'(1));
    chk("R9 xfer", 128'(xfer), 128'(0));
    chk("R9 outputs", 128'(act_f ^ 128'(act_p) ^ 128'(act_a)), 128'(0));
    rst_n = 1'b1;

    // R1 period and high width
    @(posedge sync_clk); t0 = $realtime;
    @(posedge sync_clk); t1 = $realtime;
    @(negedge sync_clk); t2 = $realtime;
    chk("R1 period", 128'(int'((t1 - t0) / 8.0)), 128'(4));
    chk("R1 high width", 128'(int'((t2 - t1) / 8.0)), 128'(2));

    // R8 staging writes do not reach outputs
    for (int c = 0; c < NCH; c++)
      for (int p = 0; p < NPR; p++) stage(c, p, 0);
    chk("R8 staged only freq", 128'(act_f), 128'(0));
    chk("R8 staged only xfer", 128'(xfer_cnt), 128'(0));

    // R3 strobe rising edge
    push_exp(0, "R3");
    drive(1'b1, 0); settle();
    chk("R3 count", 128'(xfer_cnt), 128'(1));

    // R6 held high, then falling edge
    base = xfer_cnt;
    repeat (3) @(posedge sync_clk);
    repeat (2) @(negedge clk);
    chk("R6 held high", 128'(xfer_cnt), 128'(base));
    drive(1'b0, 0); settle(); settle();
    chk("R6 falling", 128'(xfer_cnt), 128'(base));

    // R4 / R7 profile change
    push_exp(5, "R4 R7 prof5");
    drive(1'b0, 5); settle();
    chk("R4 count", 128'(xfer_cnt), 128'(base + 1));

    // R5 both triggers in one sample
    base = xfer_cnt;
    push_exp(9, "R5");
    drive(1'b1, 9); settle(); settle();
    chk("R5 single", 128'(xfer_cnt), 128'(base + 1));
    drive(1'b0, 9); settle();

    // R2 glitches between sampling edges
    base = xfer_cnt;
    @(posedge sync_clk); @(negedge clk); update = 1'b1;
    @(negedge clk); update = 1'b0;
    settle(); settle();
    chk("R2 strobe glitch", 128'(xfer_cnt), 128'(base));
    @(posedge sync_clk); @(negedge clk); profile = 4'd3;
    @(negedge clk); profile = 4'd9;
    settle(); settle();
    chk("R2 profile glitch", 128'(xfer_cnt), 128'(base));

    // R8 write on the copy edge lands at the next transfer
    push_exp(9, "R8 old");
    @(posedge sync_clk); @(negedge clk); update = 1'b1;
    @(posedge sync_clk); @(negedge clk);
    chk("R8 xfer window", 128'(xfer), 128'(1));
    wr_en = 1'b1; wr_ch = 2'd2; wr_prof = 4'd9;
    wr_f = 32'hdead_0209; wr_p = 14'h1abc; wr_a = 10'h2cd;
    @(negedge clk); wr_en = 1'b0;
    m_f[2][9] = 32'hdead_0209; m_p[2][9] = 14'h1abc; m_a[2][9] = 10'h2cd;
    drive(1'b0, 9); settle();
    push_exp(9, "R8 new");
    drive(1'b1, 9); settle();
    drive(1'b0, 9); settle();

    // R10 per-channel independence
    stage(0, 12, 2);
    stage(3, 12, 3);
    push_exp(12, "R10");
    drive(1'b0, 12); settle();

    // R7 reselect profile 0 without writes
    push_exp(0, "R7 prof0");
    drive(1'b0, 0); settle();
    chk("R7 queue drained", 128'(q_t.size()), 128'(0));
    finish_run();
  end

endmodule